// File: doc/BRIEF.md
# Run-Time Configurable Timer/Counter with Prescaler

This block is a register-mapped timer/counter. It advances on every system clock cycle or on one chosen edge of an external pin. It can optionally pass those ticks through a power-of-two prescaler. It runs as either an 8-bit or a 16-bit counter, and all of these choices are made at run time through one control register.

When the count wraps, a sticky overflow flag is raised and driven out as an interrupt request. Software typically reloads a start value after each overflow to shorten the period.

The external pin is brought into the system clock domain through a two-flop synchronizer, followed by an edge detector. The 16-bit count is accessed one byte at a time:

- Reading the low byte captures the high byte into a read buffer.
- A written high byte is held in a write buffer until the low byte is written.

Both directions therefore see one coherent 16-bit value.

Register addresses: 0 is control, 1 is the count low byte, 2 is the count high byte, and 3 is the flag register (bit 0 is the overflow flag).

Control bits:

| Bit | Meaning |
|-----|---------|
| 7 | run |
| 6 | 8-bit width |
| 5 | external source |
| 4 | falling edge |
| 3 | prescaler bypass |
| 2:0 | prescaler ratio select |

Top module: `cfg_timer`

## Requirements
- R1: After reset the control register, both count bytes, the read-back high byte and the overflow flag are all zero.
- R2: While control bit 7 is 0 the count holds its value; while it is 1 the count advances on each selected tick.
- R3: With control bit 6 set to 1, only the low byte counts and it wraps 0xFF to 0x00 with the high byte unchanged. With bit 6 set to 0, the full 16-bit value wraps 0xFFFF to 0x0000. Each wrap sets the overflow flag in the cycle of the wrap.
- R4: With control bit 5 set to 0 and bit 3 set to 1, the count advances once per system clock cycle.
- R5: With control bit 5 set to 1, the count advances once per external pin edge after the two-flop synchronizer. Bit 4 set to 0 counts rising edges and set to 1 counts falling edges. System clock cycles are then not counted.
- R6: With control bit 3 set to 0, the count advances once every 2^(S+1) ticks, where S is the value of control bits 2:0 (0 gives 1:2 and 7 gives 1:256).
- R7: A write to the count low byte clears the prescaler's partial count, so the first advance after it comes a full ratio of ticks later.
- R8: The overflow flag stays set until a write of 0 to bit 0 of address 3. A write of 1 there has no effect. If a wrap and a clearing write fall in the same cycle, the flag ends up set.
- R9: A read of address 1 with the read strobe high captures the count high byte. Address 2 then returns that captured byte, even after the live high byte moves on.
- R10: A write to address 2 changes only a holding buffer. In 16-bit mode, a write to address 1 loads the low byte and the buffered high byte in the same cycle. In 8-bit mode, a write to address 1 loads only the low byte.
- R11: A count write that coincides with a tick loads exactly the written value, and that tick does not increment the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe (captures the high byte on a low-byte read) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| extPin | input | 1 | External count input, asynchronous |
| ovfFlag | output | 1 | Sticky overflow flag / interrupt request |

## Verification
Two pairs of functions can land on the same clock edge:

- **Flag clear against wrap.** The counter is preloaded to 0xFE in 8-bit mode with the prescaler bypassed. The write of 0 to the flag register is then timed so that its edge is exactly the edge of the 0xFF to 0x00 wrap. The flag output must read 1 afterwards, and a later clearing write with no wrap must bring it to 0.
- **Count write against running tick.** A low-byte write is made while the counter runs at one tick per cycle. The value read right after must equal the written byte, not one more.

Prescaler ratios are swept over all eight selections, and each count is compared with the tick count divided by the ratio.

// File: rtl/cfg_timer_pkg.sv
`timescale 1ns/1ps
package cfg_timer_pkg;

  // Control register bit positions
  localparam int BIT_RUN    = 7;
  localparam int BIT_NARROW = 6;
  localparam int BIT_EXT    = 5;
  localparam int BIT_FALL   = 4;
  localparam int BIT_BYPASS = 3;
  localparam int SEL_LSB    = 0;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_CNT_LO = 2'd1,
    ADDR_CNT_HI = 2'd2,
    ADDR_FLAG   = 2'd3
  } regAddr_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLow;    // commit low byte (and buffered high in wide mode)
    logic loadHigh;   // fill high-byte write buffer
    logic latchHigh;  // capture live high byte for read-back
    logic advance;    // count by one
    logic clrFlag;    // software clear of overflow flag
    logic narrow;     // 8-bit mode
  } dpStrobe_t;

endpackage

// File: rtl/cfg_timer_ctrl.sv
`timescale 1ns/1ps
module cfg_timer_ctrl
  import cfg_timer_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [BYTE_W-1:0] busWdata,
  input  logic              extPin,
  output logic [BYTE_W-1:0] ctrlReg,
  output dpStrobe_t         strb
);

  localparam int PS_W = 1 << SEL_W;

  // Control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ctrlReg <= '0;
    else if (busWe && busAddr == ADDR_CTRL)
      ctrlReg <= busWdata;
  end

  logic             runOn, extSel, fallSel, bypass;
  logic [SEL_W-1:0] ratioSel;

  assign runOn    = ctrlReg[BIT_RUN];
  assign extSel   = ctrlReg[BIT_EXT];
  assign fallSel  = ctrlReg[BIT_FALL];
  assign bypass   = ctrlReg[BIT_BYPASS];
  assign ratioSel = ctrlReg[SEL_LSB +: SEL_W];

  // External input synchronizer chain
  logic [SYNC_STAGES-1:0] syncQ;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= extPin;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  logic syncOut, prevQ, extEdge;

  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncOut;
  end

  assign extEdge = fallSel ? (prevQ & ~syncOut) : (syncOut & ~prevQ);

  // Tick source and prescaler
  logic            srcTick, psTerminal, loadLow;
  logic [PS_W-1:0] psCnt, psLimit;
  logic [PS_W:0]   limWide;

  assign srcTick = runOn & (extSel ? extEdge : 1'b1);
  assign loadLow = busWe && busAddr == ADDR_CNT_LO;

  always_comb begin
    limWide = ({{PS_W{1'b0}}, 1'b1} << ({1'b0, ratioSel} + 1'b1)) - 1'b1;
    psLimit = limWide[PS_W-1:0];
  end

  assign psTerminal = (psCnt == psLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      psCnt <= '0;
    else if (loadLow)
      psCnt <= '0;
    else if (srcTick && !bypass)
      psCnt <= psTerminal ? '0 : psCnt + 1'b1;
  end

  // Strobe assembly
  always_comb begin
    strb.loadLow   = loadLow;
    strb.loadHigh  = busWe && busAddr == ADDR_CNT_HI;
    strb.latchHigh = busRe && busAddr == ADDR_CNT_LO;
    strb.advance   = bypass ? srcTick : (srcTick & psTerminal);
    strb.clrFlag   = busWe && busAddr == ADDR_FLAG && !busWdata[0];
    strb.narrow    = ctrlReg[BIT_NARROW];
  end

  // R2
  run_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[BIT_RUN] |-> !strb.advance);

  // R6
  ps_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !ctrlReg[BIT_BYPASS]) |=> psCnt == '0);

  // R7
  ps_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLow |=> psCnt == '0);

endmodule

// File: rtl/cfg_timer_dp.sv
`timescale 1ns/1ps
module cfg_timer_dp
  import cfg_timer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic [BYTE_W-1:0]   busWdata,
  output logic [2*BYTE_W-1:0] cnt,
  output logic [BYTE_W-1:0]   highRead,
  output logic                ovfFlag
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lowNow, highNow, highWrBuf;
  logic              wrap;

  assign lowNow  = cnt[BYTE_W-1:0];
  assign highNow = cnt[CNT_W-1:BYTE_W];

  assign wrap = strb.advance && !strb.loadLow &&
                (strb.narrow ? (&lowNow) : (&cnt));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.loadLow) begin
      cnt <= {strb.narrow ? highNow : highWrBuf, busWdata};
    end else if (strb.advance) begin
      if (strb.narrow) cnt <= {highNow, lowNow + BYTE_W'(1)};
      else             cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              highWrBuf <= '0;
    else if (strb.loadHigh) highWrBuf <= busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               highRead <= '0;
    else if (strb.latchHigh) highRead <= highNow;
  end

  // Set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ovfFlag <= 1'b0;
    else if (wrap)         ovfFlag <= 1'b1;
    else if (strb.clrFlag) ovfFlag <= 1'b0;
  end

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !strb.clrFlag) |=> ovfFlag);

  // R8
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(strb.advance));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.loadLow) |=> $stable(cnt));

  // R3
  narrow_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.narrow |=> $stable(cnt[CNT_W-1:BYTE_W]));

  // R11
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLow |=> cnt[BYTE_W-1:0] == $past(busWdata));

endmodule

// File: rtl/cfg_timer.sv
`timescale 1ns/1ps
module cfg_timer
  import cfg_timer_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              extPin,
  output logic              ovfFlag
);

  dpStrobe_t           strb;
  logic [BYTE_W-1:0]   ctrlReg, highRead;
  logic [2*BYTE_W-1:0] cnt;

  cfg_timer_ctrl #(
    .BYTE_W      (BYTE_W),
    .SEL_W       (SEL_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busRe    (busRe),
    .busWdata (busWdata),
    .extPin   (extPin),
    .ctrlReg  (ctrlReg),
    .strb     (strb)
  );

  cfg_timer_dp #(
    .BYTE_W (BYTE_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .cnt      (cnt),
    .highRead (highRead),
    .ovfFlag  (ovfFlag)
  );

  always_comb begin
    case (busAddr)
      ADDR_CTRL:   busRdata = ctrlReg;
      ADDR_CNT_LO: busRdata = cnt[BYTE_W-1:0];
      ADDR_CNT_HI: busRdata = highRead;
      default:     busRdata = {{(BYTE_W-1){1'b0}}, ovfFlag};
    endcase
  end

endmodule

// File: tb/tb_cfg_timer.sv
`timescale 1ns/1ps
module tb_cfg_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWe = 1'b0;
  logic       busRe = 1'b0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       extPin = 1'b0;
  logic       ovfFlag;

  int  nChk = 0;
  int  nBad = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  cfg_timer dut (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busRe    (busRe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .extPin   (extPin),
    .ovfFlag  (ovfFlag)
  );

  task automatic chk(input string tag, input int got, input int exp);
    nChk++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busAddr  = a;
    busWdata = d;
    busWe    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    busAddr = a;
    busRe   = 1'b0;
    #1 v = busRdata;
  endtask

  task automatic rd16(output int v);
    int lo;
    busAddr = 2'd1;
    busRe   = 1'b1;
    #1 lo = busRdata;
    @(posedge clk);
    @(negedge clk);
    busRe   = 1'b0;
    busAddr = 2'd2;
    #1 v = (busRdata << 8) | lo;
  endtask

  task automatic load16(input logic [7:0] cfg, input int val);
    wr(2'd0, cfg);                   // stopped, chosen mode
    wr(2'd2, val[15:8]);
    wr(2'd1, val[7:0]);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      extPin = 1'b1;
      repeat (4) @(negedge clk);
      extPin = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int v;
    int hi;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 count low", v, 0);
    rd(2'd2, v); chk("R1 count high", v, 0);
    rd(2'd3, v); chk("R1 flag reg", v, 0);
    chk("R1 flag pin", int'(ovfFlag), 0);

    // R6 prescaler sweep, 16-bit, internal source
    for (int sel = 0; sel < 8; sel++) begin
      load16(8'(sel), 0);
      wr(2'd0, 8'(8'h80 | sel));
      repeat (700) @(posedge clk);
      @(negedge clk);
      rd16(v);
      chk($sformatf("R6 ratio sel %0d", sel), v, 700 >> (sel + 1));
    end

    // R4 internal source, prescaler bypassed
    load16(8'h08, 0);
    wr(2'd0, 8'h88);
    repeat (300) @(posedge clk);
    @(negedge clk);
    rd16(v);
    chk("R4 one per cycle", v, 300);

    // R2 hold while stopped
    load16(8'h08, 16'h0010);
    repeat (20) @(negedge clk);
    rd16(v);
    chk("R2 stopped holds", v, 16'h0010);

    // R10 buffered high byte, atomic commit
    wr(2'd2, 8'h12);
    rd16(v);
    chk("R10 high write buffered only", v, 16'h0010);
    wr(2'd1, 8'h34);
    rd16(v);
    chk("R10 low write commits both", v, 16'h1234);

    // R3 8-bit wrap keeps high byte
    load16(8'h08, 16'h5AFD);
    wr(2'd0, 8'h48);
    wr(2'd2, 8'h77);
    wr(2'd1, 8'h10);
    rd16(v);
    chk("R10 narrow low write keeps high", v, 16'h5A10);
    wr(2'd1, 8'hFD);
    wr(2'd0, 8'hC8);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd16(v);
    chk("R3 narrow wrap value", v, 16'h5A02);
    chk("R3 narrow wrap flag", int'(ovfFlag), 1);

    // R8 writing 1 keeps flag, writing 0 clears
    wr(2'd3, 8'h01);
    chk("R8 write one no effect", int'(ovfFlag), 1);
    wr(2'd3, 8'h00);
    rd(2'd3, v);
    chk("R8 clear by zero", v, 0);

    // R8 set wins over clear on the same edge
    wr(2'd0, 8'h48);
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'hC8);        // edge E
    @(posedge clk);          // E+1: 0xFF
    @(negedge clk);
    wr(2'd3, 8'h00);         // edge E+2: wrap and clear together
    chk("R8 set wins over clear", int'(ovfFlag), 1);
    wr(2'd3, 8'h00);
    chk("R8 later clear", int'(ovfFlag), 0);

    // R11 write beats increment
    wr(2'd1, 8'h40);
    rd(2'd1, v);
    chk("R11 load exact", v, 8'h40);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(2'd1, v);
    chk("R11 resumes", v, 8'h43);

    // R7 prescaler cleared by count write (ratio 1:4, 8-bit)
    wr(2'd0, 8'hC1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr(2'd1, 8'h00);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(2'd1, v);
    chk("R7 no early advance", v, 0);
    @(posedge clk);
    @(negedge clk);
    rd(2'd1, v);
    chk("R7 full ratio advance", v, 1);

    // R3 16-bit wrap timing
    wr(2'd3, 8'h00);
    load16(8'h08, 16'hFFFE);
    wr(2'd0, 8'h88);
    @(posedge clk);
    @(negedge clk);
    chk("R3 no flag before wrap", int'(ovfFlag), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 wide wrap flag", int'(ovfFlag), 1);
    rd(2'd1, v);
    chk("R3 wide wrap low", v, 0);

    // R9 read-back high capture
    wr(2'd3, 8'h00);
    load16(8'h08, 16'h00FE);
    wr(2'd0, 8'h88);
    busAddr = 2'd1;
    busRe   = 1'b1;
    #1 v = busRdata;
    chk("R9 low at capture", v, 8'hFE);
    @(posedge clk);
    @(negedge clk);
    busRe = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rd(2'd2, hi);
    chk("R9 captured high stays", hi, 0);
    rd(2'd1, v);
    chk("R9 live low moved", v, 8'h03);

    // R5 external rising, falling, and through prescaler
    load16(8'h28, 0);
    wr(2'd0, 8'hA8);
    repeat (10) @(negedge clk);
    rd16(v);
    chk("R5 clock ignored in external mode", v, 0);
    pulses(5);
    rd16(v);
    chk("R5 rising edges", v, 5);
    load16(8'h38, 0);
    wr(2'd0, 8'hB8);
    pulses(5);
    rd16(v);
    chk("R5 falling edges", v, 5);
    load16(8'h20, 0);
    wr(2'd0, 8'hA0);
    pulses(6);
    rd16(v);
    chk("R5 R6 external prescaled", v, 3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule